// File: doc/BRIEF.md
# Register-Mapped Factorial Accelerator

This block is a small compute engine that sits on a memory-mapped register bus. Software writes an operand `n` into the operand register. A sequential loop then forms `n!` modulo 2^32, one multiply per clock. When the loop finishes, the result replaces the operand in that same register and the busy flag drops. Software either polls the busy flag or enables a completion request. That request is a single-cycle pulse, which interrupt logic elsewhere on the chip collects.

The map has four registers. A read-only identification word lets software confirm it has found the block. A scratch word stores the complement of each value written to it, so a bus test can tell real storage from a floating bus. The operand/result word starts the computation. The status word carries the busy flag and the completion-request enable. Only full 32-bit accesses are honoured.

Top module: `fact_accel_top`

## Requirements
- R1: A 32-bit read of offset 0x00 returns the constant 0x010000ED.
- R2: A 32-bit write to offset 0x04 stores the bitwise complement of the written data, and reading offset 0x04 returns the stored value; the stored value is 0 after reset.
- R3: A 32-bit write to offset 0x08 while idle loads the operand and sets status bit 0 (busy). Until completion, reads of offset 0x08 return the operand.
- R4: On completion, offset 0x08 holds n·(n−1)·…·1 truncated to 32 bits, and an operand of 0 yields 1.
- R5: Status bit 0 reads 1 for exactly 1+max(n,1) clock cycles after the clock edge that accepts the operand write.
- R6: A write to offset 0x08 while busy is ignored, and the running computation finishes with the result of the original operand.
- R7: A write to status offset 0x20 copies data bit 7 into status bit 7 (completion-request enable) and never changes bit 0. All other status bits read 0, and status reads 0 after reset.
- R8: `irqReq` pulses high for exactly one cycle, in the first cycle in which busy reads 0 after a completion, if status bit 7 is 1 in that cycle. This includes the case where bit 7 was written by the access accepted on the completion edge. Otherwise `irqReq` stays low.
- R9: An access whose `accSize` is not 2 (32-bit; codes 0, 1, 3 mean 8, 16 and 64 bit) has no effect and reads return 0xFFFFFFFF. Reads of unmapped offsets also return 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per access |
| rdEn | input | 1 | Read strobe, qualifies `rdata` |
| addr | input | ADDR_W | Byte offset of the access |
| accSize | input | 2 | Access width code: 0=8, 1=16, 2=32, 3=64 bit |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr`/`rdEn` |
| irqReq | output | 1 | One-cycle completion request |

## Verification
The bench sweeps every operand from 0 to 40. That range covers the 0 and 1 special cases and the region past 34, where the truncated product becomes zero. A loop with an off-by-one count would give the wrong value or latency at these points, and a missing zero case would return 0 instead of 1. The bench writes a new operand mid-run; a design that accepted it would restart and return the wrong factorial. It also sets the request enable on exactly the completion edge, and a design that sampled the enable one cycle early would drop that request. Non-word accesses and status writes with bit 0 set are tried too, so a design that decodes them would corrupt the scratch word or start a spurious computation.

// File: rtl/fact_accel_pkg.sv
package fact_accel_pkg;

  localparam logic [31:0] ID_VALUE = 32'h010000ED;

  localparam int unsigned OFS_ID      = 'h00;
  localparam int unsigned OFS_SCRATCH = 'h04;
  localparam int unsigned OFS_OPERAND = 'h08;
  localparam int unsigned OFS_STATUS  = 'h20;

  localparam int unsigned BUSY_BIT  = 0;
  localparam int unsigned IRQEN_BIT = 7;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID,
    SEL_SCRATCH,
    SEL_OPERAND,
    SEL_STATUS
  } rdSel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RUN
  } loopState_e;

  typedef struct packed {
    logic loadOp;     // capture wdata as operand
    logic scratchWr;  // store ~wdata into scratch
    logic setup;      // prime accumulator and down-counter
    logic step;       // one multiply
    logic finish;     // write final product back to operand register
  } strobes_t;

endpackage

// File: rtl/fact_accel_ctrl.sv
module fact_accel_ctrl
  import fact_accel_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        accSize,
  input  logic              enBitIn,
  input  logic              cntLast,
  output strobes_t          strb,
  output rdSel_e            rdSel,
  output logic              busy,
  output logic              irqEn,
  output logic              irqReq
);

  loopState_e state;
  logic       accOk;
  logic       wrOk;
  logic       hitId, hitScratch, hitOperand, hitStatus;
  logic       doneDly;

  assign accOk      = (accSize == SIZE_WORD);
  assign wrOk       = wrEn && accOk;
  assign hitId      = (addr == ADDR_W'(OFS_ID));
  assign hitScratch = (addr == ADDR_W'(OFS_SCRATCH));
  assign hitOperand = (addr == ADDR_W'(OFS_OPERAND));
  assign hitStatus  = (addr == ADDR_W'(OFS_STATUS));

  assign busy = (state != ST_IDLE);

  always_comb begin
    strb           = '0;
    strb.scratchWr = wrOk && hitScratch;
    strb.loadOp    = wrOk && hitOperand && (state == ST_IDLE);
    strb.setup     = (state == ST_SETUP);
    strb.step      = (state == ST_RUN);
    strb.finish    = (state == ST_RUN) && cntLast;
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (rdEn && accOk) begin
      if (hitId)           rdSel = SEL_ID;
      else if (hitScratch) rdSel = SEL_SCRATCH;
      else if (hitOperand) rdSel = SEL_OPERAND;
      else if (hitStatus)  rdSel = SEL_STATUS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (strb.loadOp) state <= ST_SETUP;
        ST_SETUP: state <= ST_RUN;
        ST_RUN:   if (strb.finish) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn   <= 1'b0;
      doneDly <= 1'b0;
    end else begin
      if (wrOk && hitStatus) irqEn <= enBitIn;
      doneDly <= strb.finish;
    end
  end

  // Enable is looked at in the cycle after busy drops.
  assign irqReq = doneDly && irqEn;

endmodule

// File: rtl/fact_accel_dpath.sv
module fact_accel_dpath
  import fact_accel_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  rdSel_e            rdSel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              irqEn,
  output logic [DATA_W-1:0] rdata,
  output logic              cntLast
);

  logic [DATA_W-1:0] opndReg;
  logic [DATA_W-1:0] scratchReg;
  logic [DATA_W-1:0] accReg;
  logic [DATA_W-1:0] cntReg;
  logic [DATA_W-1:0] factor;
  logic [DATA_W-1:0] product;
  logic [DATA_W-1:0] statusWord;

  assign factor  = (cntReg == '0) ? DATA_W'(1) : cntReg;
  assign product = accReg * factor;
  assign cntLast = (cntReg <= DATA_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opndReg    <= '0;
      scratchReg <= '0;
      accReg     <= '0;
      cntReg     <= '0;
    end else begin
      if (strb.scratchWr) scratchReg <= ~wdata;
      if (strb.loadOp) begin
        opndReg <= wdata;
      end else if (strb.finish) begin
        opndReg <= product;
      end
      if (strb.setup) begin
        accReg <= DATA_W'(1);
        cntReg <= opndReg;
      end else if (strb.step && !strb.finish) begin
        accReg <= product;
        cntReg <= cntReg - DATA_W'(1);
      end
    end
  end

  always_comb begin
    statusWord            = '0;
    statusWord[BUSY_BIT]  = busy;
    statusWord[IRQEN_BIT] = irqEn;
  end

  always_comb begin
    unique case (rdSel)
      SEL_ID:      rdata = DATA_W'(ID_VALUE);
      SEL_SCRATCH: rdata = scratchReg;
      SEL_OPERAND: rdata = opndReg;
      SEL_STATUS:  rdata = statusWord;
      default:     rdata = '1;
    endcase
  end

endmodule

// File: rtl/fact_accel_top.sv
module fact_accel_top
  import fact_accel_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        accSize,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irqReq
);

  strobes_t strb;
  rdSel_e   rdSel;
  logic     busy;
  logic     irqEn;
  logic     cntLast;

  fact_accel_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .accSize (accSize),
    .enBitIn (wdata[IRQEN_BIT]),
    .cntLast (cntLast),
    .strb    (strb),
    .rdSel   (rdSel),
    .busy    (busy),
    .irqEn   (irqEn),
    .irqReq  (irqReq)
  );

  fact_accel_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdSel   (rdSel),
    .wdata   (wdata),
    .busy    (busy),
    .irqEn   (irqEn),
    .rdata   (rdata),
    .cntLast (cntLast)
  );

endmodule

// File: rtl/fact_accel_chk.sv
module fact_accel_chk
  import fact_accel_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        accSize,
  input logic [DATA_W-1:0] rdata,
  input logic              irqReq,
  input logic              busy,
  input logic              irqEn
);

  logic wordAcc;
  assign wordAcc = (accSize == SIZE_WORD);

  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wordAcc && addr == ADDR_W'(OFS_ID)) |-> (rdata == DATA_W'(ID_VALUE))); // R1

  AST_START_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrEn && wordAcc && addr == ADDR_W'(OFS_OPERAND))); // R3

  AST_STATUS_NO_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wordAcc && addr == ADDR_W'(OFS_STATUS) && !busy) |=> !busy); // R7

  AST_IRQ_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ($fell(busy) && irqEn)); // R8

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq); // R8

  AST_BAD_SIZE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wordAcc) |-> (rdata == '1)); // R9

endmodule

bind fact_accel_top fact_accel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .addr    (addr),
  .accSize (accSize),
  .rdata   (rdata),
  .irqReq  (irqReq),
  .busy    (busy),
  .irqEn   (irqEn)
);

// File: tb/test_fact_accel_top.sv
`timescale 1ns/1ps
module test_fact_accel_top;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              wrEn;
  logic              rdEn;
  logic [ADDR_W-1:0] addr;
  logic [1:0]        accSize;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              irqReq;

  int checks = 0;
  int fails  = 0;
  bit doneFlag = 0;

  always #2 clk = ~clk;

  fact_accel_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fact_accel_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .accSize(accSize), .wdata(wdata), .rdata(rdata), .irqReq(irqReq)
  );

  function automatic logic [31:0] factRef(int n);
    logic [31:0] r = 32'd1;
    for (int k = 2; k <= n; k++) r = r * 32'(k);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d, logic [1:0] sz = 2'd2);
    addr = a; wdata = d; accSize = sz; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0; accSize = 2'd2;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd2);
    addr = a; accSize = sz; rdEn = 1'b1;
    #1;
    d = rdata;
    rdEn = 1'b0; accSize = 2'd2;
  endtask

  task automatic runOp(int n, bit en);
    logic [31:0] v;
    int cyc;
    busWrite(8'h20, en ? 32'h80 : 32'h0);
    busWrite(8'h08, 32'(n));
    busRead(8'h20, v);
    chk("R3 busy set", {31'd0, v[0]}, 32'd1);
    busRead(8'h08, v);
    chk("R3 operand readback", v, 32'(n));
    cyc = 0;
    v = 32'd1;
    while (v[0] && cyc < 100) begin
      @(posedge clk); #1;
      cyc++;
      busRead(8'h20, v);
    end
    chk("R5 latency", 32'(cyc), 32'(1 + ((n > 1) ? n : 1)));
    chk("R8 request at completion", {31'd0, irqReq}, {31'd0, en});
    @(posedge clk); #1;
    chk("R8 single cycle", {31'd0, irqReq}, 32'd0);
    busRead(8'h08, v);
    chk("R4 result", v, factRef(n));
  endtask

  initial begin
    #(4 * 200000);
    if (!doneFlag) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; accSize = 2'd2; wdata = '0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // reset state
    busRead(8'h20, v); chk("R7 status after reset", v, 32'h0);
    busRead(8'h04, v); chk("R2 scratch after reset", v, 32'h0);
    chk("R8 no request after reset", {31'd0, irqReq}, 32'd0);

    busRead(8'h00, v); chk("R1 id", v, 32'h010000ED);

    busWrite(8'h04, 32'h12345678);
    busRead(8'h04, v); chk("R2 complement", v, 32'hEDCBA987);
    busWrite(8'h04, 32'h0);
    busRead(8'h04, v); chk("R2 complement of zero", v, 32'hFFFFFFFF);

    // status writes
    busWrite(8'h20, 32'hFFFFFFFF);
    busRead(8'h20, v); chk("R7 enable set, busy untouched", v, 32'h80);
    busWrite(8'h20, 32'hFFFFFF7F);
    busRead(8'h20, v); chk("R7 enable cleared", v, 32'h0);

    // sweep operands
    for (int n = 0; n <= 40; n++) runOp(n, n[0]);

    // write during compute is ignored
    busWrite(8'h20, 32'h0);
    busWrite(8'h08, 32'd10);
    busWrite(8'h08, 32'd5);
    busRead(8'h08, v); chk("R6 operand held", v, 32'd10);
    repeat (20) @(posedge clk); #1;
    busRead(8'h08, v); chk("R6 result of first operand", v, factRef(10));

    // enable written on the completion edge
    busWrite(8'h08, 32'd4);
    repeat (4) @(posedge clk); #1;
    busWrite(8'h20, 32'h80);
    busRead(8'h20, v); chk("R8 busy cleared at completion edge", v, 32'h80);
    chk("R8 late enable still requests", {31'd0, irqReq}, 32'd1);
    @(posedge clk); #1;
    chk("R8 late enable single cycle", {31'd0, irqReq}, 32'd0);
    busRead(8'h08, v); chk("R4 result 4", v, 32'd24);

    // non-word and unmapped accesses
    busWrite(8'h04, 32'h0F0F0F0F, 2'd3);
    busRead(8'h04, v); chk("R9 dword write ignored", v, 32'hFFFFFFFF);
    busWrite(8'h04, 32'h0F0F0F0F, 2'd0);
    busRead(8'h04, v); chk("R9 byte write ignored", v, 32'hFFFFFFFF);
    busRead(8'h00, v, 2'd1); chk("R9 halfword read", v, 32'hFFFFFFFF);
    busRead(8'h10, v); chk("R9 unmapped read", v, 32'hFFFFFFFF);
    busWrite(8'h08, 32'd3, 2'd1);
    busRead(8'h20, v); chk("R9 narrow operand write no start", v, 32'h80);
    busRead(8'h08, v); chk("R9 operand unchanged", v, 32'd24);

    doneFlag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule